// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block produces the fetch address sequence for a 32-bit instruction stream that has two conditional branches, one taken on equal operands and one taken on unequal operands. Each cycle it takes the instruction word fetched at the current address and the two register values named by that word's source fields. From these it decides whether the word is a taken branch and what the word's branch target is, and it chooses the next fetch address.

A taken branch does not redirect fetch at once. The word right after the branch, the delay slot, is always fetched and executed. The redirect is held in a pending register and is applied on the next fetch advance. The target is measured from the address of the slot word, so it equals the branch address plus 4 plus four times the signed offset. A branch that lands in a slot is handled as an ordinary word. Fetch advances only when the advance enable is high, and any pending redirect is held across stalls.

Top module: `nextpc_unit`

## Requirements
- R1: While reset_n is low and after its release, pc_o is 0x00400000. Reset also drops any pending redirect, so the first advance after reset goes to 0x00400004 even if a taken branch was pending before reset.
- R2: target_o always equals pc_o + 4 + (sign-extended instr_i[15:0] shifted left by 2), modulo 2^32. For example, pc 0x00400010 with offset 3 gives 0x00400020, and offset 0xFFFE gives pc_o + 4 - 8.
- R3: A word with opcode instr_i[31:26] = 000100 (branch on equal) sets taken_o exactly when rs_val_i and rt_val_i have identical bit patterns, unless it sits in a delay slot.
- R4: A word with opcode 000101 (branch on not equal) sets taken_o exactly when rs_val_i and rt_val_i differ in any bit, unless it sits in a delay slot.
- R5: A word with any other opcode, jumps (000010) included, never sets taken_o.
- R6: When advance_i is high and there is neither a taken branch nor a pending redirect, pc_o becomes pc_o + 4 on the next clock.
- R7: When advance_i is high and taken_o is high, pc_o becomes pc_o + 4 (the slot) on the next clock. On the next clock with advance_i high after that, pc_o becomes the target of that branch.
- R8: A branch word fetched in a delay slot holds taken_o low, whatever its operands are, and has no effect on where fetch goes after the slot.
- R9: While advance_i is low, pc_o holds its value and a pending redirect is kept until the next advance.
- R10: Address arithmetic wraps modulo 2^32. A unit reset to 0xFFFFFFF0 that takes a branch with offset 4 is redirected to 0x00000004.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| reset_n | input | 1 | Synchronous active-low reset |
| advance_i | input | 1 | Fetch advance enable |
| instr_i | input | 32 | Instruction word fetched at pc_o |
| rs_val_i | input | 32 | Value of the register named by instr_i[25:21] |
| rt_val_i | input | 32 | Value of the register named by instr_i[20:16] |
| pc_o | output | 32 | Current fetch address |
| taken_o | output | 1 | The current word is a branch that will be taken |
| target_o | output | 32 | Branch target decoded from the current word and pc_o |

## Verification
The assertions assume that instr_i, rs_val_i and rt_val_i belong to the word at pc_o and stay steady around each rising edge. They also assume that the operand values match that word's source fields, because the unit cannot check this itself. The bench changes every input only on the falling edge and samples the outputs one nanosecond later, so each word is presented for exactly one sampling edge. Stalls are made only by holding advance_i low, and the bench keeps the word unchanged or changes it at a falling edge, never in between.

// File: rtl/nextpc_pkg.sv
// Package: shared opcode values and branch kinds for the next-PC unit.
// Assumes the primary opcode sits in the top six bits of the word.
package nextpc_pkg;
    localparam int OPC_W = 6;
    localparam logic [OPC_W-1:0] OPC_BR_EQ = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BR_NE = 6'b000101;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_EQ   = 2'd1,
        BK_NE   = 2'd2
    } br_kind_e;
endpackage

// File: rtl/nextpc_decode.sv
// Module: nextpc_decode
// Decodes the primary opcode, compares the two operand bit patterns and
// raises the taken flag. A word in a delay slot never raises it.
// Assumes the operands belong to the word currently presented.
module nextpc_decode
    import nextpc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  word_i,
    input  logic [XLEN-1:0]  lhs_i,
    input  logic [XLEN-1:0]  rhs_i,
    input  logic             in_slot_i,
    output br_kind_e         kind_o,
    output logic [OFF_W-1:0] offset_o,
    output logic             taken_o
);
    localparam int OPC_LSB = XLEN - OPC_W;

    logic [OPC_W-1:0] opcode;
    logic             same_bits;

    assign opcode   = word_i[XLEN-1:OPC_LSB];
    assign offset_o = word_i[OFF_W-1:0];

    // Map the opcode onto a branch kind.
    always_comb begin
        unique case (opcode)
            OPC_BR_EQ: kind_o = BK_EQ;
            OPC_BR_NE: kind_o = BK_NE;
            default:   kind_o = BK_NONE;
        endcase
    end

    // Raw bit-pattern comparison, no numeric interpretation.
    always_comb begin
        same_bits = (lhs_i == rhs_i);
    end

    // Taken when the kind's condition holds outside a delay slot.
    always_comb begin
        case (kind_o)
            BK_EQ:   taken_o = same_bits  && !in_slot_i;
            BK_NE:   taken_o = !same_bits && !in_slot_i;
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nextpc_target.sv
// Module: nextpc_target
// Forms the sequential address (pc+4) and the branch target
// (pc+4 + sign-extended word offset times four), both wrapping.
// Assumes OFF_W + 2 <= XLEN.
module nextpc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  target_o
);
    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    logic [XLEN-1:0] byte_disp;

    // Sign-extend the offset and scale words to bytes.
    always_comb begin
        byte_disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
    end

    // Slot address and target, modulo 2^XLEN.
    always_comb begin
        seq_o    = pc_i + WORD_BYTES;
        target_o = seq_o + byte_disp;
    end
endmodule

// File: rtl/nextpc_seq.sv
// Module: nextpc_seq
// Holds the PC and the pending redirect. On an advance it applies a
// pending redirect first, else records a new one and steps to the slot.
// Assumes taken_i is already low when a redirect is pending.
module nextpc_seq #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic            clk,
    input  logic            reset_n,
    input  logic            advance_i,
    input  logic            taken_i,
    input  logic [XLEN-1:0] seq_i,
    input  logic [XLEN-1:0] target_i,
    output logic [XLEN-1:0] pc_o,
    output logic            pending_o,
    output logic [XLEN-1:0] pend_tgt_o
);
    // PC update: redirect, slot step or sequential step.
    always_ff @(posedge clk) begin
        if (!reset_n) begin
            pc_o <= RESET_PC;
        end else if (advance_i) begin
            pc_o <= pending_o ? pend_tgt_o : seq_i;
        end
    end

    // Pending redirect: armed by a taken branch, cleared when applied.
    always_ff @(posedge clk) begin
        if (!reset_n) begin
            pending_o  <= 1'b0;
            pend_tgt_o <= '0;
        end else if (advance_i) begin
            pending_o <= taken_i && !pending_o;
            if (taken_i && !pending_o) begin
                pend_tgt_o <= target_i;
            end
        end
    end
endmodule

// File: rtl/nextpc_unit.sv
// Module: nextpc_unit (top)
// Next-fetch-address unit with one branch delay slot. Connects the
// decoder, the target adder and the PC/pending register stage.
// Assumes the word and operands presented match the current pc_o.
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              OFF_W    = 16,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic            clk,
    input  logic            reset_n,
    input  logic            advance_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    output logic [XLEN-1:0] pc_o,
    output logic            taken_o,
    output logic [XLEN-1:0] target_o
);
    br_kind_e         kind;
    logic [OFF_W-1:0] offset;
    logic [XLEN-1:0]  seq_addr;
    logic             pending;
    logic [XLEN-1:0]  pend_tgt;

    nextpc_decode #(.XLEN(XLEN), .OFF_W(OFF_W)) u_decode (
        .word_i    (instr_i),
        .lhs_i     (rs_val_i),
        .rhs_i     (rt_val_i),
        .in_slot_i (pending),
        .kind_o    (kind),
        .offset_o  (offset),
        .taken_o   (taken_o)
    );

    nextpc_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_target (
        .pc_i     (pc_o),
        .offset_i (offset),
        .seq_o    (seq_addr),
        .target_o (target_o)
    );

    nextpc_seq #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_seq (
        .clk        (clk),
        .reset_n    (reset_n),
        .advance_i  (advance_i),
        .taken_i    (taken_o),
        .seq_i      (seq_addr),
        .target_i   (target_o),
        .pc_o       (pc_o),
        .pending_o  (pending),
        .pend_tgt_o (pend_tgt)
    );
endmodule

// File: rtl/nextpc_unit_chk.sv
// Module: nextpc_unit_chk
// Property checker bound to nextpc_unit. Assumes inputs are steady at
// each rising edge.
module nextpc_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            reset_n,
    input logic            advance_i,
    input logic [XLEN-1:0] instr_i,
    input logic [XLEN-1:0] pc_o,
    input logic            taken_o,
    input logic [XLEN-1:0] target_o,
    input logic            pending,
    input logic [XLEN-1:0] pend_tgt
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);
    localparam logic [XLEN-1:0] EX_PC  = XLEN'(32'h0040_0010);
    localparam logic [XLEN-1:0] EX_TGT = XLEN'(32'h0040_0020);

    logic [5:0] opc;
    assign opc = instr_i[XLEN-1:XLEN-6];

    AST_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!reset_n)
        !advance_i |=> $stable(pc_o)); // R9
    AST_STALL_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!reset_n)
        (!advance_i && pending) |=> pending); // R9
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!reset_n)
        (advance_i && !taken_o && !pending) |=> (pc_o == $past(pc_o) + STEP)); // R6
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!reset_n)
        (advance_i && taken_o) |=> (pc_o == $past(pc_o) + STEP)); // R7
    AST_REDIRECT: assert property (@(posedge clk) disable iff (!reset_n)
        (advance_i && pending) |=> (pc_o == $past(pend_tgt))); // R7
    AST_SLOT_QUIET: assert property (@(posedge clk) disable iff (!reset_n)
        pending |-> !taken_o); // R8
    AST_OTHER_OPS: assert property (@(posedge clk) disable iff (!reset_n)
        (opc != 6'b000100 && opc != 6'b000101) |-> !taken_o); // R5
    AST_TARGET_EXAMPLE: assert property (@(posedge clk) disable iff (!reset_n)
        (pc_o == EX_PC && instr_i[15:0] == 16'd3) |-> (target_o == EX_TGT)); // R2
endmodule

bind nextpc_unit nextpc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .reset_n   (reset_n),
    .advance_i (advance_i),
    .instr_i   (instr_i),
    .pc_o      (pc_o),
    .taken_o   (taken_o),
    .target_o  (target_o),
    .pending   (pending),
    .pend_tgt  (pend_tgt)
);

// File: tb/nextpc_unit_test.sv
// Bench for nextpc_unit: a vector table walked by one loop, then
// directed tests for stalls, reset and address wrap.
module nextpc_unit_test;
    logic        clk = 1'b0;
    logic        reset_n = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_v = '0;
    logic [31:0] rt_v = '0;
    logic [31:0] pc;
    logic        taken;
    logic [31:0] tgt;

    logic        w_adv = 1'b0;
    logic [31:0] w_instr = '0;
    logic [31:0] w_pc;
    logic        w_taken;
    logic [31:0] w_tgt;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    nextpc_unit uut (
        .clk(clk), .reset_n(reset_n), .advance_i(adv), .instr_i(instr),
        .rs_val_i(rs_v), .rt_val_i(rt_v),
        .pc_o(pc), .taken_o(taken), .target_o(tgt)
    );

    nextpc_unit #(.RESET_PC(32'hFFFF_FFF0)) uut_wrap (
        .clk(clk), .reset_n(reset_n), .advance_i(w_adv), .instr_i(w_instr),
        .rs_val_i(32'd9), .rt_val_i(32'd9),
        .pc_o(w_pc), .taken_o(w_taken), .target_o(w_tgt)
    );

    // Row: instr, rs, rt, taken, target, next pc (161 bits).
    localparam int NV = 9;
    localparam logic [160:0] TBL [0:NV-1] = '{
        {32'h0000_0000,             32'd0, 32'd0,          1'b0, 32'h0040_0004, 32'h0040_0004},
        {6'd4, 5'd1, 5'd2, 16'd3,   32'd5, 32'd6,          1'b0, 32'h0040_0014, 32'h0040_0008},
        {6'd5, 5'd3, 5'd4, 16'd0,   32'd7, 32'd7,          1'b0, 32'h0040_000C, 32'h0040_000C},
        {6'd2, 26'h3,               32'd4, 32'd4,          1'b0, 32'h0040_001C, 32'h0040_0010},
        {6'd4, 5'd0, 5'd9, 16'd3,   32'd9, 32'd9,          1'b1, 32'h0040_0020, 32'h0040_0014},
        {6'd5, 5'd1, 5'd2, 16'h10,  32'd1, 32'd2,          1'b0, 32'h0040_0058, 32'h0040_0020},
        {6'd5, 5'd1, 5'd2, 16'hFFFE,32'd1, 32'd2,          1'b1, 32'h0040_001C, 32'h0040_0024},
        {32'h0000_0000,             32'd3, 32'd4,          1'b0, 32'h0040_0028, 32'h0040_001C},
        {6'd4, 5'd5, 5'd6, 16'd1,   32'd0, 32'h8000_0000,  1'b0, 32'h0040_0024, 32'h0040_0020}
    };
    localparam string TAG [0:NV-1] = '{
        "R6 nop", "R3 beq unequal", "R4 bne equal", "R5 jump",
        "R3 beq equal R2", "R8 branch in slot", "R4 bne differ R10 negative",
        "R7 slot then redirect", "R3 beq sign bit differs"
    };

    task automatic chk32(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Present one word at the falling edge, check outputs, clock once.
    task automatic step(input string what, input logic a, input logic [31:0] w,
                        input logic [31:0] x, input logic [31:0] y,
                        input logic e_tk, input logic [31:0] e_tg, input logic [31:0] e_pc);
        @(negedge clk);
        adv = a; instr = w; rs_v = x; rt_v = y;
        #1;
        chk32({what, " taken"}, {31'd0, taken}, {31'd0, e_tk});
        chk32({what, " target"}, tgt, e_tg);
        @(posedge clk);
        #1;
        chk32({what, " next pc"}, pc, e_pc);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk32("R1 pc in reset", pc, 32'h0040_0000);
        @(negedge clk);
        reset_n = 1'b1;
        #1;
        chk32("R1 pc after release", pc, 32'h0040_0000);

        for (int i = 0; i < NV; i++) begin
            step(TAG[i], 1'b1, TBL[i][160:129], TBL[i][128:97], TBL[i][96:65],
                 TBL[i][64], TBL[i][63:32], TBL[i][31:0]);
        end

        // R9: stall with a redirect pending. pc is 0x00400020.
        step("R4 bne arm", 1'b1, {6'd5, 5'd1, 5'd2, 16'd5}, 32'd1, 32'd2,
             1'b1, 32'h0040_0038, 32'h0040_0024);
        for (int k = 0; k < 3; k++) begin
            step("R9 stall pending", 1'b0, {6'd4, 5'd1, 5'd1, 16'd8}, 32'd6, 32'd6,
                 1'b0, 32'h0040_0048, 32'h0040_0024);
        end
        step("R9 redirect kept", 1'b1, 32'h0, 32'd0, 32'd0,
             1'b0, 32'h0040_0028, 32'h0040_0038);
        step("R9 stall idle", 1'b0, 32'h0, 32'd0, 32'd0,
             1'b0, 32'h0040_003C, 32'h0040_0038);

        // R1: reset drops a pending redirect.
        step("R3 beq arm", 1'b1, {6'd4, 5'd1, 5'd1, 16'd16}, 32'd2, 32'd2,
             1'b1, 32'h0040_007C, 32'h0040_003C);
        @(negedge clk);
        reset_n = 1'b0; adv = 1'b0;
        @(posedge clk);
        #1;
        chk32("R1 reset pc", pc, 32'h0040_0000);
        @(negedge clk);
        reset_n = 1'b1;
        step("R1 pending cleared", 1'b1, 32'h0, 32'd0, 32'd0,
             1'b0, 32'h0040_0004, 32'h0040_0004);

        // R10: wrap past 2^32 on the second instance.
        @(negedge clk);
        w_adv = 1'b1; w_instr = {6'd4, 5'd1, 5'd1, 16'd4};
        #1;
        chk32("R10 wrap target", w_tgt, 32'h0000_0004);
        chk32("R10 wrap taken", {31'd0, w_taken}, 32'd1);
        @(posedge clk);
        #1;
        chk32("R10 slot pc", w_pc, 32'hFFFF_FFF4);
        @(negedge clk);
        w_instr = 32'h0;
        @(posedge clk);
        #1;
        chk32("R10 wrapped pc", w_pc, 32'h0000_0004);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule